// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and moves data between them in either direction. Each direction owns a capture register with a dedicated capture clock. On a rising edge of that clock the register samples the bus it listens to. A per-direction select then decides what goes out on the far side: either the value on the opposite bus right now (transparent mode) or the value held in that direction's register (replay mode).

An active-low enable and a direction input choose which side, if any, is driven. With the enable high both sides are isolated, but both registers keep capturing. A system can therefore park A data in one register and B data in the other at the same moment, and replay either one later. Each bidirectional pin group is modelled as an input vector, an output vector and an output-enable vector, so the block can be synthesized and tested without tri-state nets. A build-time parameter selects an inverting output path.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `cap_ab_clk` with `rst_n` high, the A-to-B register loads `a_in`. Between its own edges it holds its value.
- R2: On each rising edge of `cap_ba_clk` with `rst_n` high, the B-to-A register loads `b_in`. Between its own edges it holds its value.
- R3: If `rst_n` is low at a rising edge of a register's capture clock, that register is cleared to zero. The reset is synchronous to each register's own clock.
- R4: While `en_n` is 1 (isolation), `a_oe` and `b_oe` are both all zeros.
- R5: While `en_n` is 0, `dir_a2b` = 1 sets `b_oe` to all ones and `a_oe` to all zeros. `dir_a2b` = 0 sets `a_oe` to all ones and `b_oe` to all zeros. Each enable vector is always either all ones or all zeros.
- R6: `b_out` carries `a_in` when `sel_ab_stored` = 0 and the A-to-B register when `sel_ab_stored` = 1, whatever the enable and direction.
- R7: `a_out` carries `b_in` when `sel_ba_stored` = 0 and the B-to-A register when `sel_ba_stored` = 1, whatever the enable and direction.
- R8: Captures into both registers work for every value of `en_n` and `dir_a2b`. Both registers may capture at the same edge while the block is isolated.
- R9: `a_oe` and `b_oe` are never nonzero at the same time.
- R10: With `INVERT` = 1, `a_out` and `b_out` carry the bitwise complement of the selected data, while the registers still hold the true captured value. With `INVERT` = 0 the data passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_ab_clk | input | 1 | Capture clock of the A-to-B register (rising edge) |
| cap_ba_clk | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst_n | input | 1 | Active-low reset, sampled on each capture clock |
| en_n | input | 1 | Active-low output enable; 1 isolates both sides |
| dir_a2b | input | 1 | 1: drive B from A side; 0: drive A from B side |
| sel_ab_stored | input | 1 | 0: live `a_in` to B; 1: stored A-to-B value |
| sel_ba_stored | input | 1 | 0: live `b_in` to A; 1: stored B-to-A value |
| a_in | input | WIDTH | Value sensed on the A pins |
| a_out | output | WIDTH | Value offered to the A pins |
| a_oe | output | WIDTH | Drive enable for the A pins |
| b_in | input | WIDTH | Value sensed on the B pins |
| b_out | output | WIDTH | Value offered to the B pins |
| b_oe | output | WIDTH | Drive enable for the B pins |

## Verification
The assertions check four things on every cycle and every capture edge:
- the two drive-enable vectors are mutually exclusive;
- each enable vector is uniform;
- isolation really releases both sides;
- each register loads what its bus carried at its own edge, or zero under reset.

Other behaviour can only be shown through the bench's scenarios. These are the full sweep of enable, direction and both selects against a model, the survival of stored data across switches into isolation and back, simultaneous dual capture while isolated, and the complemented outputs of the inverting build.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the registered bus transceiver.
// Assumes: direction encoding 1 = A drives B, 0 = B drives A.
package xcvr_pkg;
    typedef enum logic {
        XFER_B_TO_A = 1'b0,
        XFER_A_TO_B = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
// Module: one direction's storage register.
// Loads d on the rising edge of clk; a low rst_n at that edge clears it.
// Assumes: clk is a dedicated capture clock, reset is synchronous to it.
module xcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the bus value, or clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_path_mux.sv
`timescale 1ns/1ps
// Module: output data path of one direction.
// Picks live or stored data, then applies optional inversion.
// Assumes: INVERT is a build-time choice (0 or 1); storage is never inverted.
module xcvr_path_mux #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] picked;

    // Choose between the live opposite bus and the register.
    always_comb picked = use_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            // Inverting variant: complement on the way out.
            always_comb data_out = ~picked;
        end else begin : g_true
            // Non-inverting variant: pass through.
            always_comb data_out = picked;
        end
    endgenerate
endmodule

// File: rtl/xcvr_dir_ctrl.sv
`timescale 1ns/1ps
// Module: decides which side is driven.
// Assumes: en_n active low; direction encoded per xcvr_pkg::xfer_dir_e.
module xcvr_dir_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             en_n,
    input  logic             dir_a2b,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_oe
);
    import xcvr_pkg::*;

    xfer_dir_e dir;
    logic      drive_a;
    logic      drive_b;

    // Decode enable and direction into one drive flag per side.
    always_comb begin
        dir     = xfer_dir_e'(dir_a2b);
        drive_b = !en_n && (dir == XFER_A_TO_B);
        drive_a = !en_n && (dir == XFER_B_TO_A);
    end

    // Spread each flag across the full pin group.
    always_comb begin
        a_oe = {WIDTH{drive_a}};
        b_oe = {WIDTH{drive_b}};
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
// Module: registered bidirectional bus transceiver (top).
// Two capture registers, each on its own clock; per-direction live/stored
// select; enable/direction control of the two pin groups.
// Assumes: the pins are split into in/out/oe vectors; INVERT is 0 or 1.
module bus_xcvr_reg #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             cap_ab_clk,
    input  logic             cap_ba_clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             dir_a2b,
    input  logic             sel_ab_stored,
    input  logic             sel_ba_stored,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;

    // A-to-B storage, sampled from the A side.
    xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(cap_ab_clk), .rst_n(rst_n), .d(a_in), .q(ab_q)
    );

    // B-to-A storage, sampled from the B side.
    xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(cap_ba_clk), .rst_n(rst_n), .d(b_in), .q(ba_q)
    );

    // Data headed for the B pins.
    xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_ab (
        .use_stored(sel_ab_stored), .live(a_in), .stored(ab_q), .data_out(b_out)
    );

    // Data headed for the A pins.
    xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_ba (
        .use_stored(sel_ba_stored), .live(b_in), .stored(ba_q), .data_out(a_out)
    );

    // Drive-enable decode.
    xcvr_dir_ctrl #(.WIDTH(WIDTH)) u_dir (
        .en_n(en_n), .dir_a2b(dir_a2b), .a_oe(a_oe), .b_oe(b_oe)
    );
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
// Module: property checker for bus_xcvr_reg, attached by bind.
// Assumes: capture clocks stay low while rst_n changes.
module xcvr_checker #(
    parameter int WIDTH = 8
) (
    input logic             cap_ab_clk,
    input logic             cap_ba_clk,
    input logic             rst_n,
    input logic             en_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_oe,
    input logic [WIDTH-1:0] ab_q,
    input logic [WIDTH-1:0] ba_q
);
    // Continuous checks on the drive enables once out of reset.
    always_comb begin
        if (rst_n === 1'b1) begin
            assert_oe_exclusive_R9: assert (!((|a_oe) && (|b_oe)));
            assert_oe_uniform_R5: assert ((a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));
            if (en_n === 1'b1) begin
                assert_isolation_R4: assert (a_oe == '0 && b_oe == '0);
            end
        end
    end

    // A-to-B register holds what A carried at the previous capture edge.
    assert_capture_ab_R1: assert property (@(posedge cap_ab_clk) disable iff (!rst_n)
        $past(rst_n) |-> ab_q == $past(a_in));

    // B-to-A register holds what B carried at the previous capture edge.
    assert_capture_ba_R2: assert property (@(posedge cap_ba_clk) disable iff (!rst_n)
        $past(rst_n) |-> ba_q == $past(b_in));

    // Reset at an edge leaves the register cleared.
    assert_reset_ab_R3: assert property (@(posedge cap_ab_clk)
        !rst_n |=> ab_q == '0);
    assert_reset_ba_R3: assert property (@(posedge cap_ba_clk)
        !rst_n |=> ba_q == '0);
endmodule

bind bus_xcvr_reg xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk), .rst_n(rst_n),
    .en_n(en_n), .a_in(a_in), .b_in(b_in), .a_oe(a_oe), .b_oe(b_oe),
    .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver task applies stimulus and pushes the
// expected port values; a monitor on the falling clock edge pops and compares.
module bus_xcvr_reg_tb_top;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a_out, a_oe, b_out, b_oe;
        logic [W-1:0] a_out_inv, b_out_inv;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic cap_ab_clk = 1'b0, cap_ba_clk = 1'b0;
    logic rst_n = 1'b0, en_n = 1'b1, dir_a2b = 1'b0;
    logic sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic [W-1:0] a_out_n, a_oe_n, b_out_n, b_oe_n;

    logic [W-1:0] m_ab = '0, m_ba = '0;
    exp_t q[$];
    exp_t it;
    int checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) dut_i (
        .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk), .rst_n(rst_n),
        .en_n(en_n), .dir_a2b(dir_a2b), .sel_ab_stored(sel_ab), .sel_ba_stored(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
        .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk), .rst_n(rst_n),
        .en_n(en_n), .dir_a2b(dir_a2b), .sel_ab_stored(sel_ab), .sel_ba_stored(sel_ba),
        .a_in(a_in), .a_out(a_out_n), .a_oe(a_oe_n), .b_in(b_in), .b_out(b_out_n), .b_oe(b_oe_n)
    );

    // Driver: apply one step, pulse capture clocks, push the expectation.
    task automatic step(input logic r, input logic e, input logic d,
                        input logic sab, input logic sba,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic pab, input logic pba, input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
        rst_n = r; en_n = e; dir_a2b = d; sel_ab = sab; sel_ba = sba;
        a_in = a; b_in = b;
        #2;
        if (pab) begin cap_ab_clk = 1'b1; m_ab = r ? a : '0; end
        if (pba) begin cap_ba_clk = 1'b1; m_ba = r ? b : '0; end
        x.b_out = sab ? m_ab : a;
        x.a_out = sba ? m_ba : b;
        x.b_out_inv = ~x.b_out;
        x.a_out_inv = ~x.a_out;
        x.b_oe = (!e && d) ? '1 : '0;
        x.a_oe = (!e && !d) ? '1 : '0;
        x.tag = tag;
        q.push_back(x);
    endtask

    // Monitor: compare both builds against the popped expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (a_out !== it.a_out || b_out !== it.b_out || a_oe !== it.a_oe || b_oe !== it.b_oe) begin
                errors++;
                $display("FAIL %s: a_out=%h b_out=%h a_oe=%h b_oe=%h expected a_out=%h b_out=%h a_oe=%h b_oe=%h",
                         it.tag, a_out, b_out, a_oe, b_oe, it.a_out, it.b_out, it.a_oe, it.b_oe);
            end
            checks++;
            if (a_out_n !== it.a_out_inv || b_out_n !== it.b_out_inv || a_oe_n !== it.a_oe || b_oe_n !== it.b_oe) begin
                errors++;
                $display("FAIL R10 %s: inv a_out=%h b_out=%h a_oe=%h b_oe=%h expected a_out=%h b_out=%h a_oe=%h b_oe=%h",
                         it.tag, a_out_n, b_out_n, a_oe_n, b_oe_n, it.a_out_inv, it.b_out_inv, it.a_oe, it.b_oe);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R3: reset at capture edges clears both registers; isolated (R4).
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b1, 1'b1, "R3 reset clears");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'hC3, 1'b1, 1'b1, "R3 reset held");

        // R8: simultaneous capture while isolated.
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3, 1'b1, 1'b1, "R8 dual capture isolated");

        // R4 R5 R6 R7 R9: sweep enable, direction and both selects.
        for (int i = 0; i < 16; i++) begin
            step(1'b1, i[3], i[2], i[1], i[0], 8'(8'h11 * i + 1), 8'(8'hF0 - 8'h07 * i),
                 1'b0, 1'b0, $sformatf("R4 R5 R6 R7 R9 combo %0d", i));
        end

        // R1 R2: capture A only; B-to-A register keeps its old value.
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h96, 8'h0F, 1'b1, 1'b0, "R1 capture A only, R2 hold");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, "R1 hold after capture");

        // R2 R8: capture B while driving A from B.
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 8'hE7, 1'b0, 1'b1, "R2 capture B while enabled");

        // Isolation and back: stored data survives.
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88, 1'b0, 1'b0, "R4 isolate keeps registers");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h66, 8'h99, 1'b0, 1'b0, "R5 re-enable A to B stored");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 8'hBB, 1'b0, 1'b0, "R5 re-enable B to A stored");

        // R6 R7: live data while registers hold other values.
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h5A, 1'b0, 1'b0, "R6 R7 live pass");

        // R3: a later reset clears again.
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, "R3 second reset");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h21, 8'h43, 1'b0, 1'b0, "R3 cleared after reset");

        @(posedge clk);
        #1;
        cap_ab_clk = 1'b0; cap_ba_clk = 1'b0;
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule